// File: doc/BRIEF.md
# Two-Digit Key History Display

This block remembers the two most recently registered hexadecimal keys and shows them on a pair of seven-segment digits. The digits share one set of segment lines. Each cycle in which the registration strobe is high is one new key. On that key, the digit that held the latest key now holds the older key, and the incoming code becomes the latest key. At all other times the stored values stay as they are, whatever the key-code input does.

A free-running slot counter lights the two digits in turn. Every slot has the same length, so both digits get the same duty and the same apparent brightness. The switch rate is set high enough that the display does not flicker. For a few cycles at the start of each slot, both enables are off and all segments are dark. This keeps the previous digit's pattern from appearing faintly on the next digit (ghosting). The default parameters give a 1 kHz switch rate from a 20 MHz clock.

Top module: `key_hist_disp`

## Requirements
- R1: While reset is active and just after it is released, both stored digits hold 0. Scanning starts on the latest-key digit at the first cycle of its slot, with both enables off and all segments off.
- R2: At a rising clock edge where `new_key_i` is high, the older digit takes the previous latest-key value and the latest-key digit takes `key_code_i`. The new values are displayed from the following cycle.
- R3: If `new_key_i` is low, changes on `key_code_i` leave both stored digits unchanged.
- R4: At most one digit enable is high at a time. When neither is high, `seg_no` is 7'h7F (all segments off).
- R5: Each slot lasts SLOT_CYC = CLK_HZ/SWITCH_HZ cycles. Slots alternate strictly: `dig_en_o[0]` (latest key), then `dig_en_o[1]` (older key).
- R6: The first BLANK_CYC cycles of every slot have both enables low. The remaining SLOT_CYC-BLANK_CYC cycles have only that slot's enable high.
- R7: Over any whole number of slot pairs, the two digits are lit for the same number of cycles.
- R8: `seg_no` is active-low, with bit 0 = segment a through bit 6 = segment g. Before inversion, the patterns for codes 0..F are 3F,06,5B,4F,66,6D,7D,07,7F,6F,77,7C,39,5E,79,71. This gives lowercase b and d.
- R9: A registration strobe in the last cycle of a slot updates the history and still lets the digit switch happen on time. Neither action delays or drops the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| new_key_i | input | 1 | One-cycle registration strobe |
| key_code_i | input | 4 | Hex code of the registered key |
| seg_no | output | 7 | Shared segment lines, active low, bit0=a .. bit6=g |
| dig_en_o | output | 2 | Digit enables, active high; [0] latest key, [1] older key |

## Verification
Two actions can fall in the same cycle: a history shift and a slot switch. The bench lines up on the first lit cycle of the latest-key slot and counts forward to that slot's final cycle. It then raises the strobe in that exact cycle. The pass condition has three parts. The older-key enable must appear exactly BLANK_CYC cycles later. It must show the former latest key. The next latest-key slot must show the new code.

// File: rtl/key_hist_pkg.sv
package key_hist_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEG_W  = 7;
  localparam int unsigned NUM_DIG = 2;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SEG_W-1:0]  seg_t;

  // active-low pattern, bit0=a .. bit6=g
  function automatic seg_t hex_to_seg_n(input code_t c);
    seg_t on;
    unique case (c)
      4'h0: on = 7'h3F;
      4'h1: on = 7'h06;
      4'h2: on = 7'h5B;
      4'h3: on = 7'h4F;
      4'h4: on = 7'h66;
      4'h5: on = 7'h6D;
      4'h6: on = 7'h7D;
      4'h7: on = 7'h07;
      4'h8: on = 7'h7F;
      4'h9: on = 7'h6F;
      4'hA: on = 7'h77;
      4'hB: on = 7'h7C;
      4'hC: on = 7'h39;
      4'hD: on = 7'h5E;
      4'hE: on = 7'h79;
      default: on = 7'h71;
    endcase
    return ~on;
  endfunction
endpackage

// File: rtl/key_hist_shift.sv
module key_hist_shift
  import key_hist_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  code_t                    code_i,
  output logic [DEPTH-1:0][CODE_W-1:0] hist_o
);
  logic [DEPTH-1:0][CODE_W-1:0] hist_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    code_t nxt;
    if (i == 0) begin : g_head
      assign nxt = code_i;
    end else begin : g_tail
      assign nxt = hist_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hist_q[i] <= '0;
      else if (load_i) hist_q[i] <= nxt;
    end
  end

  assign hist_o = hist_q;

  AST_SHIFT_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (hist_q[0] == $past(code_i)) && (hist_q[1] == $past(hist_q[0]))); // R2
  AST_HOLD_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(hist_q)); // R3
endmodule

// File: rtl/digit_scan_timer.sv
module digit_scan_timer #(
  parameter int unsigned SLOT_CYC  = 20000,
  parameter int unsigned BLANK_CYC = 200,
  parameter int unsigned NUM_DIG   = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  output logic [$clog2(NUM_DIG)-1:0] sel_o,
  output logic                       blank_o
);
  localparam int unsigned CNT_W = $clog2(SLOT_CYC);
  localparam int unsigned SEL_W = $clog2(NUM_DIG);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOT_CYC - 1);
  localparam logic [SEL_W-1:0] SLAST = SEL_W'(NUM_DIG - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      sel_q <= (sel_q == SLAST) ? '0 : sel_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // dark at slot start so the old pattern never meets the new enable
  assign blank_o = (cnt_q < CNT_W'(BLANK_CYC));
  assign sel_o   = sel_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R5
  AST_SEL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (sel_q != $past(sel_q)) && blank_o); // R5
  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != LAST) |=> $stable(sel_q)); // R7
endmodule

// File: rtl/key_hist_disp.sv
module key_hist_disp
  import key_hist_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 20_000_000,
  parameter int unsigned SWITCH_HZ = 1000,
  parameter int unsigned BLANK_CYC = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       new_key_i,
  input  logic [3:0] key_code_i,
  output logic [6:0] seg_no,
  output logic [1:0] dig_en_o
);
  localparam int unsigned SLOT_CYC = CLK_HZ / SWITCH_HZ;
  localparam int unsigned SEL_W    = $clog2(NUM_DIG);

  logic [NUM_DIG-1:0][CODE_W-1:0] hist;
  seg_t                           seg_d [NUM_DIG];
  logic [SEL_W-1:0]               sel;
  logic                           blank;

  key_hist_shift #(.DEPTH(NUM_DIG)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (new_key_i),
    .code_i (key_code_i),
    .hist_o (hist)
  );

  digit_scan_timer #(
    .SLOT_CYC  (SLOT_CYC),
    .BLANK_CYC (BLANK_CYC),
    .NUM_DIG   (NUM_DIG)
  ) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_o   (sel),
    .blank_o (blank)
  );

  for (genvar d = 0; d < NUM_DIG; d++) begin : g_dec
    assign seg_d[d] = hex_to_seg_n(hist[d]);
  end

  always_comb begin
    seg_no   = '1;
    dig_en_o = '0;
    if (!blank) begin
      seg_no        = seg_d[sel];
      dig_en_o[sel] = 1'b1;
    end
  end

  AST_ONE_DIGIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dig_en_o)); // R4
  AST_DARK_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o == '0) |-> (seg_no == 7'h7F)); // R4
  AST_LIT_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o != '0) |-> (seg_no != 7'h7F)); // R8
  AST_BLANK_ON_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dig_en_o != '0) |=> (dig_en_o == $past(dig_en_o)) || (dig_en_o == '0)); // R6
endmodule

// File: tb/sim_key_hist_disp.sv
module sim_key_hist_disp;
  localparam int unsigned CLK_HZ = 1000;
  localparam int unsigned SW_HZ  = 100;
  localparam int unsigned BLANK  = 2;
  localparam int unsigned SLOT   = CLK_HZ / SW_HZ;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       new_key = 1'b0;
  logic [3:0] code = 4'h0;
  logic [6:0] seg_n;
  logic [1:0] en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  key_hist_disp #(.CLK_HZ(CLK_HZ), .SWITCH_HZ(SW_HZ), .BLANK_CYC(BLANK)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .new_key_i(new_key), .key_code_i(code),
    .seg_no(seg_n), .dig_en_o(en)
  );

  always #10 clk = ~clk;

  function automatic logic [6:0] exp_seg(input logic [3:0] c);
    logic [6:0] t [16] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
                           7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return ~t[c];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_key(input logic [3:0] c);
    @(negedge clk); code = c; new_key = 1'b1;
    @(negedge clk); new_key = 1'b0;
  endtask

  // land on the first lit cycle of the latest-key slot
  task automatic sync_recent();
    do @(negedge clk); while (en != 2'b00);
    do @(negedge clk); while (en != 2'b01);
  endtask

  task automatic read_digits(output logic [6:0] rec, output logic [6:0] old);
    do @(negedge clk); while (en != 2'b01);
    rec = seg_n;
    do @(negedge clk); while (en != 2'b10);
    old = seg_n;
  endtask

  task automatic t_reset();
    logic [6:0] r, o;
    @(negedge clk);
    chk("R1 en in reset", en, 0);
    chk("R1 seg in reset", seg_n, 7'h7F);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 blank after release", en, 0);
    repeat (BLANK - 1) @(negedge clk);
    chk("R1 first lit is latest digit", en, 2'b01);
    read_digits(r, o);
    chk("R1 latest digit zero", r, exp_seg(4'h0));
    chk("R1 older digit zero", o, exp_seg(4'h0));
  endtask

  task automatic t_shift();
    logic [6:0] r, o;
    send_key(4'h3);
    send_key(4'hA);
    read_digits(r, o);
    chk("R2 latest=A", r, exp_seg(4'hA));
    chk("R2 older=3", o, exp_seg(4'h3));
    send_key(4'hB);
    send_key(4'hD);
    read_digits(r, o);
    chk("R2 latest=d", r, exp_seg(4'hD));
    chk("R2 older=b", o, exp_seg(4'hB));
  endtask

  task automatic t_ignore();
    logic [6:0] r, o;
    for (int k = 0; k < 3 * SLOT; k++) begin
      @(negedge clk); code = 4'(k);
    end
    read_digits(r, o);
    chk("R3 latest unchanged", r, exp_seg(4'hD));
    chk("R3 older unchanged", o, exp_seg(4'hB));
  endtask

  task automatic t_timing();
    int lit, drk;
    logic [1:0] first;
    sync_recent();
    first = en;
    lit = 1;
    while (en == first) begin @(negedge clk); if (en == first) lit++; end
    drk = 0;
    while (en == 2'b00) begin
      drk++;
      chk("R4 dark segs", seg_n, 7'h7F);
      @(negedge clk);
    end
    chk("R6 lit run length", lit, SLOT - BLANK);
    chk("R6 blank run length", drk, BLANK);
    chk("R5 alternation to older", en, 2'b10);
  endtask

  task automatic t_balance();
    int n0 = 0, n1 = 0, bad = 0;
    sync_recent();
    for (int k = 0; k < 8 * SLOT; k++) begin
      if (en == 2'b01) n0++;
      else if (en == 2'b10) n1++;
      else if (en != 2'b00 || seg_n != 7'h7F) bad++;
      @(negedge clk);
    end
    chk("R7 latest lit cycles", n0, 4 * (SLOT - BLANK));
    chk("R7 older lit cycles", n1, 4 * (SLOT - BLANK));
    chk("R4 no overlap or stray segs", bad, 0);
  endtask

  task automatic t_decode();
    logic [6:0] r, o;
    for (int c = 0; c < 16; c++) begin
      send_key(4'(c));
      read_digits(r, o);
      chk($sformatf("R8 code %0h", c), r, exp_seg(4'(c)));
    end
  endtask

  task automatic t_coincide();
    logic [6:0] r, o;
    send_key(4'h7);
    send_key(4'h2);
    sync_recent();
    repeat (SLOT - BLANK - 1) @(negedge clk);
    chk("R9 still latest slot end", en, 2'b01);
    code = 4'h5; new_key = 1'b1;
    @(negedge clk); new_key = 1'b0;
    chk("R9 blank after switch", en, 0);
    repeat (BLANK) @(negedge clk);
    chk("R9 older slot on time", en, 2'b10);
    chk("R9 older took prior latest", seg_n, exp_seg(4'h2));
    read_digits(r, o);
    chk("R9 latest is new code", r, exp_seg(4'h5));
  endtask

  initial begin
    t_reset();
    t_shift();
    t_ignore();
    t_timing();
    t_balance();
    t_decode();
    t_coincide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule